// File: doc/BRIEF.md
# Packet Receive FIFO with Status Tags

This block buffers the byte stream that a receive packet processor produces and hands it to a host read port. Every stored byte travels with a three-bit tag that marks packet start, packet end and an error or abort condition, so the host sees the delineation without reparsing the data. Both sides run on one clock, and each transfer moves one byte.

The controller keeps a write pointer, a read pointer and a fill level that runs from 0 to the full depth. From the level it reports empty, full and a data-available flag. Data-available rises once the level reaches a threshold set at an input. A write that finds no room is dropped, and a read that finds no data returns nothing new. Each of these events sets a sticky flag, and the flag stays set until a clear input is pulsed.

Top module: `pkt_rx_fifo`

## Requirements
- R1: After reset the level is 0, empty is 1, full and both sticky flags are 0, and the read data and read tag outputs are 0.
- R2: Bytes leave in the order they were written, each with its own tag (rd_sop, rd_eop, rd_err). The byte and tag for an accepted read appear in the cycle after the read strobe.
- R3: A write while full with no read in the same cycle is dropped. The level stays at 256, the stored contents are unchanged and overflow becomes 1.
- R4: A read while empty leaves rd_data and the tag outputs at their previous values, keeps the level at 0 and sets underflow to 1.
- R5: An accepted read and an accepted write in the same cycle leave the level unchanged. This holds when the FIFO is full: the read frees one place and the write takes it.
- R6: empty is 1 exactly when the level is 0, and full is 1 exactly when the level is 256.
- R7: avail is 1 exactly when the level is greater than or equal to avail_thresh. A threshold of 0 keeps avail at 1.
- R8: overflow and underflow stay set until sticky_clr is high at a clock edge. If a new event occurs in the same cycle as the clear, the flag stays set.
- R9: A read and a write in the same cycle while empty accept the write and reject the read. The level becomes 1 and underflow is set.
- R10: level counts accepted writes minus accepted reads, from 0 to 256 inclusive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Common clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe from the packet processor |
| wr_data | input | 8 | Byte to store |
| wr_sop | input | 1 | Tag: byte starts a packet |
| wr_eop | input | 1 | Tag: byte ends a packet |
| wr_err | input | 1 | Tag: packet error or abort |
| rd_en | input | 1 | Host read strobe |
| rd_data | output | 8 | Byte read, valid the cycle after rd_en |
| rd_sop | output | 1 | Packet-start tag of the byte read |
| rd_eop | output | 1 | Packet-end tag of the byte read |
| rd_err | output | 1 | Error tag of the byte read |
| avail_thresh | input | 9 | Level at which avail rises |
| sticky_clr | input | 1 | Clears overflow and underflow |
| empty | output | 1 | No bytes stored |
| avail | output | 1 | Level at or above avail_thresh |
| full | output | 1 | No free place |
| level | output | 9 | Bytes stored |
| overflow | output | 1 | Sticky: a write was dropped |
| underflow | output | 1 | Sticky: a read found no data |

## Verification
The cases of interest are those where a read and a write fall in the same cycle at an edge of the fill range. When the FIFO is full, the bench fills it to 256 bytes and then strobes both ports together. It expects the oldest byte to come out, the level to stay at 256 and overflow not to be set by that write. When the FIFO is empty, the bench strobes both ports and expects the write to land, the level to become 1, underflow to be set and rd_data to keep its old value. It then reads the tail of the queue to confirm that the byte written alongside the full-state read was stored behind the others.

// File: rtl/pkt_rx_fifo_pkg.sv
package pkt_rx_fifo_pkg;

  typedef struct packed {
    logic err;
    logic eop;
    logic sop;
  } pkt_tag_t;

  localparam int unsigned TAG_W = $bits(pkt_tag_t);

  // advance a ring pointer with explicit wrap, valid for any depth
  function automatic logic [31:0] ring_step(input logic [31:0] p, input int unsigned depth);
    return (p == depth - 1) ? 32'd0 : p + 32'd1;
  endfunction

  // new fill level from accepted transfers
  function automatic logic [31:0] level_step(input logic [31:0] lvl, input logic put, input logic take);
    logic [31:0] r;
    r = lvl;
    if (put && !take) r = lvl + 32'd1;
    else if (take && !put) r = lvl - 32'd1;
    return r;
  endfunction

endpackage

// File: rtl/pkt_rx_fifo_ctrl.sv
module pkt_rx_fifo_ctrl
  import pkt_rx_fifo_pkg::*;
#(
  parameter int unsigned DEPTH = 256,
  parameter int unsigned PTR_W = 8,
  parameter int unsigned CNT_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             rd_en,
  output logic             wr_ok,
  output logic             rd_ok,
  output logic [PTR_W-1:0] wptr,
  output logic [PTR_W-1:0] rptr,
  output logic [CNT_W-1:0] level
);
  localparam logic [CNT_W-1:0] LVL_MAX = CNT_W'(DEPTH);

  logic is_empty, is_full;
  assign is_empty = (level == '0);
  assign is_full  = (level == LVL_MAX);

  // a read frees a place in the same cycle, so a full FIFO still takes a write then
  assign rd_ok = rd_en && !is_empty;
  assign wr_ok = wr_en && (!is_full || rd_en);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wptr  <= '0;
      rptr  <= '0;
      level <= '0;
    end else begin
      if (wr_ok) wptr <= PTR_W'(ring_step(32'(wptr), DEPTH));
      if (rd_ok) rptr <= PTR_W'(ring_step(32'(rptr), DEPTH));
      level <= CNT_W'(level_step(32'(level), wr_ok, rd_ok));
    end
  end

  p_level_range_r10: assert property (@(posedge clk) disable iff (!rst_n)
    level <= LVL_MAX);
  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (is_full && wr_en && !rd_en) |=> (level == LVL_MAX));
  p_empty_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (is_empty && rd_en && !wr_en) |=> (level == '0));
  p_simul_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ok && rd_ok) |=> $stable(level));
  p_empty_both_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (is_empty && rd_en && wr_en) |=> (level == CNT_W'(1)));
endmodule

// File: rtl/pkt_rx_fifo_mem.sv
module pkt_rx_fifo_mem #(
  parameter int unsigned DEPTH  = 256,
  parameter int unsigned PTR_W  = 8,
  parameter int unsigned WORD_W = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [PTR_W-1:0]  waddr,
  input  logic [WORD_W-1:0] wword,
  input  logic              re,
  input  logic [PTR_W-1:0]  raddr,
  output logic [WORD_W-1:0] rword
);
  logic [WORD_W-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (we) store[waddr] <= wword;
  end

  // registered read port; holds its value when no read is accepted
  always_ff @(posedge clk) begin
    if (!rst_n) rword <= '0;
    else if (re) rword <= store[raddr];
  end

  p_rd_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !re |=> $stable(rword));
endmodule

// File: rtl/pkt_rx_fifo_flags.sv
module pkt_rx_fifo_flags #(
  parameter int unsigned DEPTH = 256,
  parameter int unsigned CNT_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] level,
  input  logic [CNT_W-1:0] thresh,
  input  logic             wr_en,
  input  logic             wr_ok,
  input  logic             rd_en,
  input  logic             rd_ok,
  input  logic             clr,
  output logic             empty,
  output logic             full,
  output logic             avail,
  output logic             overflow,
  output logic             underflow
);
  localparam logic [CNT_W-1:0] LVL_MAX = CNT_W'(DEPTH);

  logic ovf_evt, unf_evt;
  assign ovf_evt = wr_en && !wr_ok;
  assign unf_evt = rd_en && !rd_ok;

  assign empty = (level == '0);
  assign full  = (level == LVL_MAX);
  assign avail = (level >= thresh);

  // a new event beats a clear in the same cycle
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      overflow  <= 1'b0;
      underflow <= 1'b0;
    end else begin
      overflow  <= ovf_evt || (overflow && !clr);
      underflow <= unf_evt || (underflow && !clr);
    end
  end

  p_ovf_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_evt |=> overflow);
  p_unf_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
    unf_evt |=> underflow);
  p_flag_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(empty && full));
  p_ovf_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (overflow && !clr) |=> overflow);
  p_unf_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (underflow && !clr) |=> underflow);
endmodule

// File: rtl/pkt_rx_fifo.sv
module pkt_rx_fifo
  import pkt_rx_fifo_pkg::*;
#(
  parameter int unsigned DEPTH  = 256,
  parameter int unsigned DATA_W = 8,
  localparam int unsigned PTR_W  = $clog2(DEPTH),
  localparam int unsigned CNT_W  = $clog2(DEPTH + 1),
  localparam int unsigned WORD_W = DATA_W + TAG_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              wr_sop,
  input  logic              wr_eop,
  input  logic              wr_err,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_sop,
  output logic              rd_eop,
  output logic              rd_err,
  input  logic [CNT_W-1:0]  avail_thresh,
  input  logic              sticky_clr,
  output logic              empty,
  output logic              avail,
  output logic              full,
  output logic [CNT_W-1:0]  level,
  output logic              overflow,
  output logic              underflow
);
  logic             wr_ok, rd_ok;
  logic [PTR_W-1:0] wptr, rptr;
  pkt_tag_t         in_tag, out_tag;
  logic [WORD_W-1:0] in_word, out_word;

  assign in_tag  = '{err: wr_err, eop: wr_eop, sop: wr_sop};
  assign in_word = {in_tag, wr_data};
  assign out_tag = pkt_tag_t'(out_word[WORD_W-1:DATA_W]);
  assign rd_data = out_word[DATA_W-1:0];
  assign rd_sop  = out_tag.sop;
  assign rd_eop  = out_tag.eop;
  assign rd_err  = out_tag.err;

  pkt_rx_fifo_ctrl #(.DEPTH(DEPTH), .PTR_W(PTR_W), .CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
    .wr_ok(wr_ok), .rd_ok(rd_ok), .wptr(wptr), .rptr(rptr), .level(level)
  );

  pkt_rx_fifo_mem #(.DEPTH(DEPTH), .PTR_W(PTR_W), .WORD_W(WORD_W)) u_mem (
    .clk(clk), .rst_n(rst_n), .we(wr_ok), .waddr(wptr), .wword(in_word),
    .re(rd_ok), .raddr(rptr), .rword(out_word)
  );

  pkt_rx_fifo_flags #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_flags (
    .clk(clk), .rst_n(rst_n), .level(level), .thresh(avail_thresh),
    .wr_en(wr_en), .wr_ok(wr_ok), .rd_en(rd_en), .rd_ok(rd_ok), .clr(sticky_clr),
    .empty(empty), .full(full), .avail(avail),
    .overflow(overflow), .underflow(underflow)
  );
endmodule

// File: tb/pkt_rx_fifo_test.sv
module pkt_rx_fifo_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0, wr_sop = 1'b0, wr_eop = 1'b0, wr_err = 1'b0;
  logic [7:0] wr_data = '0;
  logic rd_en = 1'b0, sticky_clr = 1'b0;
  logic [8:0] avail_thresh = 9'd1;
  logic [7:0] rd_data;
  logic rd_sop, rd_eop, rd_err, empty, avail, full, overflow, underflow;
  logic [8:0] level;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  pkt_rx_fifo uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .wr_sop(wr_sop), .wr_eop(wr_eop), .wr_err(wr_err), .rd_en(rd_en),
    .rd_data(rd_data), .rd_sop(rd_sop), .rd_eop(rd_eop), .rd_err(rd_err),
    .avail_thresh(avail_thresh), .sticky_clr(sticky_clr), .empty(empty),
    .avail(avail), .full(full), .level(level),
    .overflow(overflow), .underflow(underflow)
  );

  // {err, eop, sop, data}: a short packet with an errored tail byte
  localparam logic [10:0] VEC [0:5] = '{
    {3'b001, 8'hA1}, {3'b000, 8'h3C}, {3'b000, 8'hFF},
    {3'b010, 8'h00}, {3'b011, 8'h7E}, {3'b110, 8'h55}
  };

  function automatic logic [10:0] fill_word(input int i);
    return {3'(i % 8), 8'(i) ^ 8'h5A};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(input logic w, input logic r, input logic c, input logic [10:0] word);
    @(negedge clk);
    wr_en = w; rd_en = r; sticky_clr = c;
    wr_data = word[7:0]; wr_sop = word[8]; wr_eop = word[9]; wr_err = word[10];
    @(posedge clk);
    #1;
    wr_en = 1'b0; rd_en = 1'b0; sticky_clr = 1'b0;
  endtask

  function automatic logic [10:0] out_word();
    return {rd_err, rd_eop, rd_sop, rd_data};
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(5.0 * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R1 level", 32'(level), 0);
    check("R1 empty", 32'(empty), 1);
    check("R1 full", 32'(full), 0);
    check("R1 flags", 32'({overflow, underflow}), 0);
    check("R1 rd out", 32'(out_word()), 0);
    @(negedge clk); rst_n = 1'b1;

    // table walk: write each vector, then read back in order (R2, R10)
    for (int i = 0; i < 6; i++) begin
      step(1, 0, 0, VEC[i]);
      check("R10 level up", 32'(level), 32'(i + 1));
    end
    for (int i = 0; i < 6; i++) begin
      step(0, 1, 0, 11'h0);
      check("R2 order", 32'(out_word()), 32'(VEC[i]));
    end
    check("R6 empty after drain", 32'(empty), 1);

    // threshold (R7)
    avail_thresh = 9'd3;
    step(1, 0, 0, 11'h001);
    step(1, 0, 0, 11'h002);
    check("R7 below", 32'(avail), 0);
    step(1, 0, 0, 11'h003);
    check("R7 at", 32'(avail), 1);
    for (int i = 0; i < 3; i++) step(0, 1, 0, 11'h0);
    avail_thresh = 9'd0;
    #1;
    check("R7 zero", 32'(avail), 1);
    avail_thresh = 9'd1;

    // fill to capacity
    for (int i = 0; i < 256; i++) step(1, 0, 0, fill_word(i));
    check("R6 full", 32'(full), 1);
    check("R10 max", 32'(level), 256);
    step(1, 0, 0, 11'h0EE);
    check("R3 level", 32'(level), 256);
    check("R3 ovf", 32'(overflow), 1);
    // read and write together at full (R5)
    step(1, 1, 0, 11'h4DD);
    check("R5 level", 32'(level), 256);
    check("R5 out", 32'(out_word()), 32'(fill_word(0)));
    for (int i = 1; i < 256; i++) begin
      step(0, 1, 0, 11'h0);
      check("R3 contents", 32'(out_word()), 32'(fill_word(i)));
    end
    step(0, 1, 0, 11'h0);
    check("R5 tail", 32'(out_word()), 32'h4DD);
    check("R6 empty", 32'(empty), 1);
    check("R8 ovf held", 32'(overflow), 1);

    // underflow (R4)
    step(0, 1, 0, 11'h0);
    check("R4 hold", 32'(out_word()), 32'h4DD);
    check("R4 level", 32'(level), 0);
    check("R4 unf", 32'(underflow), 1);
    step(0, 0, 1, 11'h0);
    check("R8 cleared", 32'({overflow, underflow}), 0);

    // empty with both strobes (R9)
    step(1, 1, 0, 11'h211);
    check("R9 level", 32'(level), 1);
    check("R9 unf", 32'(underflow), 1);
    check("R9 hold", 32'(out_word()), 32'h4DD);
    step(0, 0, 1, 11'h0);
    step(0, 1, 0, 11'h0);
    check("R9 stored", 32'(out_word()), 32'h211);
    // event in the same cycle as clear (R8)
    step(0, 1, 1, 11'h0);
    check("R8 set wins", 32'(underflow), 1);

    // reset mid-run (R1)
    step(1, 0, 0, 11'h123);
    @(negedge clk); rst_n = 1'b0;
    @(posedge clk); #1;
    check("R1 rerst level", 32'(level), 0);
    check("R1 rerst flags", 32'({overflow, underflow}), 0);
    finish_run();
  end
endmodule